// File: doc/BRIEF.md
# Buffered Center-Aligned PWM Timebase

This block produces the shared timebase for a complementary, center-aligned PWM pair. Two up/down counters run in lockstep: a lead lane and a lag lane, held apart by a fixed offset. The offset is the dead-time value when dead time is enabled, and one otherwise. The lag lane swings between zero and the carrier limit. The lead lane swings between the offset and its own upper limit. The point where the lead lane turns over at its limit is the crest of the carrier. The point where the lag lane turns over at zero is the trough.

Software never touches the two active limits. It writes a lead-limit buffer and a carrier buffer, then arms a transfer by writing the arm register. At the next transfer point picked by the timing select (crest, trough or both), both buffers are copied into the active limits on the same clock edge. The copy happens only if the buffered pair meets two rules: the carrier exceeds twice the dead time plus two, and the lead limit equals the carrier plus the offset. A pair that breaks either rule is dropped and raises a configuration-error flag. A crest transfer shapes the following carrier cycle. A trough transfer already shapes the crest of the cycle in progress.

Top module: `cpwmTimebase`

## Requirements
- R1: After reset both counters read 0, the direction output reads 1 (up), both strobes and the error flag read 0, and the counters stay still until `start` is pulsed.
- R2: A `start` pulse loads the lag counter with 0 and the lead counter with the offset: the dead-time register when `deadEn` is 1, otherwise 1. The direction is set to up.
- R3: On each enabled cycle both counters step by one in the same direction. The direction turns to down when the lead counter sits at the active lead limit, and back to up when the lag counter sits at 0. Going from one crest to the next takes twice the carrier limit in enabled cycles.
- R4: `crest` is high for exactly the one enabled cycle in which the count is up and the lead counter equals its limit; the lag counter then equals the carrier limit. `trough` is high for exactly the one enabled cycle in which the count is down and the lag counter is 0. The two strobes are never high together.
- R5: While `clkEn` is 0 the counters and the direction hold, and neither strobe is raised.
- R6: Register addresses: 0 is the lead-limit buffer, 1 the carrier buffer, 2 the dead-time register, 3 the arm register (data ignored). Writing the buffers without arming leaves the active limits unchanged.
- R7: Once armed, both buffers are copied into the active limits together at the next selected transfer point. The arm then clears, so one arm write yields at most one transfer.
- R8: `xferSel` bit 0 makes the crest a transfer point and bit 1 makes the trough one. 2'b11 allows both. 2'b00 allows none, and the arm stays pending.
- R9: A crest transfer takes effect from the next crest after that crest. A trough transfer takes effect at the crest of the carrier cycle that trough begins.
- R10: At a transfer point the buffered pair is applied only if carrier > 2*deadtime+2 and lead limit == carrier + offset. Otherwise the active limits are unchanged. At every armed transfer point `cfgErr` takes the inverse of that test, and the arm is consumed either way.
- R11: An arm write in the same cycle as a transfer point does not use that point; it waits for the next one. A buffer write in the same cycle as a transfer does not affect that transfer, which copies the earlier buffer contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Loads the initial counter values and begins counting |
| clkEn | input | 1 | Count enable; counting holds while low |
| deadEn | input | 1 | 1 selects the dead-time offset, 0 selects an offset of one |
| xferSel | input | 2 | Transfer timing: bit 0 crest, bit 1 trough |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 lead buffer, 1 carrier buffer, 2 dead time, 3 arm) |
| wrData | input | W | Register write data |
| cntA | output | W | Lead counter |
| cntB | output | W | Lag counter |
| countUp | output | 1 | Count direction, 1 = up |
| crest | output | 1 | One-cycle crest strobe |
| trough | output | 1 | One-cycle trough strobe |
| cfgErr | output | 1 | Result of the last attempted transfer; 1 = rejected |

## Verification
Two events can land on the same cycle: the arm write and a transfer point, and a buffer write and the transfer it feeds. The bench finds a crest by watching the `crest` strobe, then drives the arm write so that it lands on that same edge. It then requires the peak count of the following crest to still be the old carrier, with the new one showing only one crest later. It also re-arms, and on the edge where the transfer fires it overwrites the carrier buffer. It then requires the next peak to show the value that was buffered before that write.

// File: rtl/pwmTimebasePkg.sv
package pwmTimebasePkg;

  typedef enum logic [1:0] {
    REG_LEAD_BUF    = 2'd0,
    REG_CARRIER_BUF = 2'd1,
    REG_DEAD        = 2'd2,
    REG_ARM         = 2'd3
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;   // start: load initial counter values
    logic step;   // advance counters by one
    logic xfer;   // copy buffers into active limits
  } tbStrobes_t;

endpackage

// File: rtl/pwmPeriodCheck.sv
module pwmPeriodCheck #(
  parameter int W = 16
) (
  input  logic [W-1:0] carrierBuf,
  input  logic [W-1:0] leadBuf,
  input  logic [W-1:0] deadTime,
  input  logic         deadEn,
  output logic         cfgOk
);
  // two guard bits so the doubled dead time and the sums never wrap
  localparam int XW = W + 2;

  logic [XW-1:0] minCarrier;
  logic [XW-1:0] wantLead;
  logic [XW-1:0] offsetX;
  logic          carrierFits;
  logic          leadMatches;

  assign offsetX     = deadEn ? XW'(deadTime) : XW'(1);
  assign minCarrier  = XW'({deadTime, 1'b0}) + XW'(2);
  assign wantLead    = XW'(carrierBuf) + offsetX;
  assign carrierFits = XW'(carrierBuf) > minCarrier;
  assign leadMatches = XW'(leadBuf) == wantLead;
  assign cfgOk       = carrierFits && leadMatches;

endmodule

// File: rtl/pwmTimebaseCtrl.sv
module pwmTimebaseCtrl
  import pwmTimebasePkg::*;
#(
  parameter int W           = 16,
  parameter int DEF_CARRIER = 16,
  parameter int DEF_DEAD    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         clkEn,
  input  logic         deadEn,
  input  logic [1:0]   xferSel,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         crestEv,
  input  logic         troughEv,
  input  logic         cfgOk,
  output tbStrobes_t   strobes,
  output logic [W-1:0] leadBuf,
  output logic [W-1:0] carrierBuf,
  output logic [W-1:0] deadTime,
  output logic [W-1:0] offset,
  output logic         cfgErr
);
  localparam logic [W-1:0] RST_CARRIER = W'(DEF_CARRIER);
  localparam logic [W-1:0] RST_DEAD    = W'(DEF_DEAD);
  localparam logic [W-1:0] RST_LEAD    = W'(DEF_CARRIER + DEF_DEAD);

  regSel_e sel;
  logic    armed;
  logic    running;
  logic    armWr;
  logic    xferPoint;
  logic    xferTry;

  assign sel       = regSel_e'(wrAddr);
  assign armWr     = wrEn && (sel == REG_ARM);
  assign xferPoint = (xferSel[0] && crestEv) || (xferSel[1] && troughEv);
  assign xferTry   = armed && xferPoint;
  assign offset    = deadEn ? deadTime : W'(1);

  assign strobes.load = start;
  assign strobes.step = running && clkEn && !start;
  assign strobes.xfer = xferTry && cfgOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      leadBuf    <= RST_LEAD;
      carrierBuf <= RST_CARRIER;
      deadTime   <= RST_DEAD;
      armed      <= 1'b0;
      running    <= 1'b0;
      cfgErr     <= 1'b0;
    end else begin
      if (wrEn) begin
        unique case (sel)
          REG_LEAD_BUF:    leadBuf    <= wrData;
          REG_CARRIER_BUF: carrierBuf <= wrData;
          REG_DEAD:        deadTime   <= wrData;
          REG_ARM:         ;
        endcase
      end
      armed <= armWr || (armed && !xferTry);
      if (start)   running <= 1'b1;
      if (xferTry) cfgErr  <= !cfgOk;
    end
  end

  // R7
  arm_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && xferPoint && !armWr) |=> !armed);

  // R11
  arm_pending_chk: assert property (@(posedge clk) disable iff (rst)
    armWr |=> armed);

  // R10
  reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && xferPoint && !cfgOk) |=> cfgErr);

  // R10
  accept_flag_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.xfer |=> !cfgErr);

endmodule

// File: rtl/pwmTimebaseDp.sv
module pwmTimebaseDp
  import pwmTimebasePkg::*;
#(
  parameter int W           = 16,
  parameter int DEF_CARRIER = 16,
  parameter int DEF_DEAD    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  tbStrobes_t   strobes,
  input  logic [W-1:0] offset,
  input  logic [W-1:0] leadBuf,
  input  logic [W-1:0] carrierBuf,
  output logic [W-1:0] cntA,
  output logic [W-1:0] cntB,
  output logic         countUp,
  output logic         crestEv,
  output logic         troughEv
);
  localparam int LANES = 2;   // lane 0 lead, lane 1 lag
  localparam logic [W-1:0] RST_CARRIER = W'(DEF_CARRIER);
  localparam logic [W-1:0] RST_LEAD    = W'(DEF_CARRIER + DEF_DEAD);

  logic [W-1:0] limA;
  logic [W-1:0] limB;
  logic [W-1:0] laneCnt  [LANES];
  logic [W-1:0] laneInit [LANES];
  logic         atTop;
  logic         atZero;
  logic         moveUp;

  assign laneInit[0] = offset;
  assign laneInit[1] = '0;
  assign cntA        = laneCnt[0];
  assign cntB        = laneCnt[1];

  assign atTop    = (cntA == limA);
  assign atZero   = (cntB == '0);
  assign moveUp   = countUp ? !atTop : atZero;
  assign crestEv  = strobes.step && countUp && atTop;
  assign troughEv = strobes.step && !countUp && atZero;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst)               laneCnt[g] <= '0;
      else if (strobes.load) laneCnt[g] <= laneInit[g];
      else if (strobes.step) laneCnt[g] <= moveUp ? laneCnt[g] + W'(1)
                                                  : laneCnt[g] - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countUp <= 1'b1;
      limA    <= RST_LEAD;
      limB    <= RST_CARRIER;
    end else begin
      if (strobes.load)      countUp <= 1'b1;
      else if (strobes.step) countUp <= moveUp;
      if (strobes.xfer) begin
        limA <= leadBuf;
        limB <= carrierBuf;
      end
    end
  end

  // R3
  lane_gap_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.step |=> (cntA - cntB) == $past(cntA - cntB));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.step && !strobes.load) |=> ($stable(cntA) && $stable(cntB) && $stable(countUp)));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(crestEv && troughEv));

  // R7
  xfer_copy_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.xfer |=> (limA == $past(leadBuf) && limB == $past(carrierBuf)));

  // R6
  limit_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.xfer |=> ($stable(limA) && $stable(limB)));

endmodule

// File: rtl/cpwmTimebase.sv
module cpwmTimebase
  import pwmTimebasePkg::*;
#(
  parameter int W           = 16,
  parameter int DEF_CARRIER = 16,
  parameter int DEF_DEAD    = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         clkEn,
  input  logic         deadEn,
  input  logic [1:0]   xferSel,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] cntA,
  output logic [W-1:0] cntB,
  output logic         countUp,
  output logic         crest,
  output logic         trough,
  output logic         cfgErr
);
  tbStrobes_t   strobes;
  logic [W-1:0] leadBuf;
  logic [W-1:0] carrierBuf;
  logic [W-1:0] deadTime;
  logic [W-1:0] offset;
  logic         cfgOk;

  pwmTimebaseCtrl #(.W(W), .DEF_CARRIER(DEF_CARRIER), .DEF_DEAD(DEF_DEAD)) ctrl (
    .clk(clk), .rst(rst), .start(start), .clkEn(clkEn), .deadEn(deadEn),
    .xferSel(xferSel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .crestEv(crest), .troughEv(trough), .cfgOk(cfgOk), .strobes(strobes),
    .leadBuf(leadBuf), .carrierBuf(carrierBuf), .deadTime(deadTime),
    .offset(offset), .cfgErr(cfgErr)
  );

  pwmPeriodCheck #(.W(W)) check (
    .carrierBuf(carrierBuf), .leadBuf(leadBuf), .deadTime(deadTime),
    .deadEn(deadEn), .cfgOk(cfgOk)
  );

  pwmTimebaseDp #(.W(W), .DEF_CARRIER(DEF_CARRIER), .DEF_DEAD(DEF_DEAD)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .offset(offset),
    .leadBuf(leadBuf), .carrierBuf(carrierBuf), .cntA(cntA), .cntB(cntB),
    .countUp(countUp), .crestEv(crest), .troughEv(trough)
  );

endmodule

// File: tb/cpwmTimebase_test.sv
module cpwmTimebase_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         clkEn = 1'b1;
  logic         deadEn = 1'b1;
  logic [1:0]   xferSel = 2'b01;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] cntA, cntB;
  logic         countUp, crest, trough, cfgErr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  cpwmTimebase #(.W(W), .DEF_CARRIER(16), .DEF_DEAD(2)) uut (
    .clk(clk), .rst(rst), .start(start), .clkEn(clkEn), .deadEn(deadEn),
    .xferSel(xferSel), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntA(cntA), .cntB(cntB), .countUp(countUp), .crest(crest),
    .trough(trough), .cfgErr(cfgErr)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #4;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    nxt();
    wrEn = 1'b0;
  endtask

  task automatic seekCrest(output int peak, output int lead, output int steps);
    steps = 0; peak = -1; lead = -1;
    for (int i = 0; i < 400; i++) begin
      nxt(); steps++;
      if (crest) begin peak = int'(cntB); lead = int'(cntA); break; end
    end
    if (peak < 0) chkEq("R4 crest seen", 0, 1);
  endtask

  task automatic seekTrough(output int lead);
    lead = -1;
    for (int i = 0; i < 400; i++) begin
      nxt();
      if (trough) begin lead = int'(cntA); break; end
    end
    if (lead < 0) chkEq("R4 trough seen", 0, 1);
  endtask

  task automatic pulseStart();
    start = 1'b1; nxt(); start = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) nxt();
    rst = 1'b0;
    nxt();
    chkEq("R1 cntA", int'(cntA), 0);
    chkEq("R1 cntB", int'(cntB), 0);
    chkEq("R1 countUp", int'(countUp), 1);
    chkEq("R1 strobes", int'(crest) + int'(trough), 0);
    chkEq("R1 cfgErr", int'(cfgErr), 0);
    repeat (4) nxt();
    chkEq("R1 idle before start", int'(cntB), 0);
  endtask

  task automatic testStartCount();
    int p, a, s;
    pulseStart();
    chkEq("R2 lag load", int'(cntB), 0);
    chkEq("R2 lead load dead", int'(cntA), 2);
    chkEq("R2 up", int'(countUp), 1);
    nxt();
    chkEq("R3 step lag", int'(cntB), 1);
    chkEq("R3 step lead", int'(cntA), 3);
    seekCrest(p, a, s);
    chkEq("R4 crest lag at carrier", p, 16);
    chkEq("R4 crest lead at limit", a, 18);
    nxt();
    chkEq("R4 crest one cycle", int'(crest), 0);
    chkEq("R3 reversed", int'(countUp), 0);
    chkEq("R3 down step", int'(cntB), 15);
    seekTrough(a);
    chkEq("R4 trough lead", a, 2);
    chkEq("R4 trough lag", int'(cntB), 0);
    nxt();
    chkEq("R3 back up", int'(countUp), 1);
    chkEq("R4 trough one cycle", int'(trough), 0);
    seekCrest(p, a, s);
    seekCrest(p, a, s);
    chkEq("R3 crest spacing", s, 32);
  endtask

  task automatic testHold();
    int p, a, s;
    seekCrest(p, a, s);
    clkEn = 1'b0;
    #1;
    chkEq("R5 no crest when held", int'(crest), 0);
    repeat (4) nxt();
    chkEq("R5 lag held", int'(cntB), 16);
    chkEq("R5 dir held", int'(countUp), 1);
    chkEq("R5 no strobes", int'(crest) + int'(trough), 0);
    clkEn = 1'b1;
    #1;
    chkEq("R5 crest resumes", int'(crest), 1);
  endtask

  task automatic testBufferOnly();
    int p, a, s;
    wr(2'd1, 10); wr(2'd0, 12);
    seekCrest(p, a, s);
    seekCrest(p, a, s);
    chkEq("R6 no arm no change", p, 16);
  endtask

  task automatic testCrestXfer();
    int p, a, s;
    xferSel = 2'b01;
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    chkEq("R9 crest xfer old cycle", p, 16);
    seekCrest(p, a, s);
    chkEq("R7 new carrier", p, 10);
    chkEq("R7 new lead", a, 12);
    chkEq("R10 valid no err", int'(cfgErr), 0);
    wr(2'd1, 20); wr(2'd0, 22);
    seekCrest(p, a, s);
    seekCrest(p, a, s);
    chkEq("R7 single transfer per arm", p, 10);
  endtask

  task automatic testTroughXfer();
    int p, a, s;
    xferSel = 2'b10;
    wr(2'd1, 14); wr(2'd0, 16);
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    chkEq("R9 trough xfer current cycle", p, 14);
  endtask

  task automatic testModes();
    int p, a, s;
    xferSel = 2'b00;
    wr(2'd1, 12); wr(2'd0, 14);
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    seekCrest(p, a, s);
    chkEq("R8 mode none holds", p, 14);
    nxt();
    xferSel = 2'b11;
    seekCrest(p, a, s);
    chkEq("R8 both modes trough first", p, 12);
  endtask

  task automatic testInvalid();
    int p, a, s;
    xferSel = 2'b01;
    wr(2'd1, 6); wr(2'd0, 8);
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    nxt();
    chkEq("R10 carrier rule err", int'(cfgErr), 1);
    seekCrest(p, a, s);
    chkEq("R10 rejected not applied", p, 12);
    wr(2'd1, 11); wr(2'd0, 12);
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    nxt();
    chkEq("R10 lead mismatch err", int'(cfgErr), 1);
    seekCrest(p, a, s);
    chkEq("R10 mismatch not applied", p, 12);
    wr(2'd0, 13);
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    nxt();
    chkEq("R10 err cleared", int'(cfgErr), 0);
    seekCrest(p, a, s);
    chkEq("R10 fixed pair applied", p, 11);
  endtask

  task automatic testCoincide();
    int p, a, s;
    wr(2'd1, 8); wr(2'd0, 10);
    seekCrest(p, a, s);
    wr(2'd3, 0);            // lands on this crest edge
    seekCrest(p, a, s);
    chkEq("R11 arm at point waits", p, 11);
    seekCrest(p, a, s);
    chkEq("R11 applied at next point", p, 8);
    wr(2'd1, 9); wr(2'd0, 11);
    seekCrest(p, a, s);
    wr(2'd3, 0);
    seekCrest(p, a, s);     // transfer fires on this edge
    wr(2'd1, 30);           // same edge as the transfer
    seekCrest(p, a, s);
    chkEq("R11 buffer write vs xfer", p, 9);
    chkEq("R11 no err", int'(cfgErr), 0);
  endtask

  task automatic testNoDead();
    int p, a, s;
    deadEn = 1'b0;
    xferSel = 2'b11;
    wr(2'd1, 8); wr(2'd0, 9);
    wr(2'd3, 0);
    seekCrest(p, a, s);
    seekCrest(p, a, s);
    chkEq("R10 offset-one pair valid", int'(cfgErr), 0);
    pulseStart();
    chkEq("R2 lead load no dead", int'(cntA), 1);
    chkEq("R2 lag load no dead", int'(cntB), 0);
    seekCrest(p, a, s);
    chkEq("R3 peak no dead", p, 8);
    chkEq("R4 lead limit no dead", a, 9);
  endtask

  initial begin
    testReset();
    testStartCount();
    testHold();
    testBufferOnly();
    testCrestXfer();
    testTroughXfer();
    testModes();
    testInvalid();
    testCoincide();
    testNoDead();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule